// File: doc/BRIEF.md
# NAND Flash Command Responder

This block plays the device side of an asynchronous NAND flash pin interface inside a larger chip. The strobes and the bus are sampled on the local clock. A command byte is latched on the rising edge of the write strobe while command latch is high. An address byte is latched the same way while address latch is high. Output data moves on to the next item on the rising edge of the read strobe. Chip enable is active low and gates every strobe. The bus is 8 or 16 bits wide, set by a parameter.

The responder serves four operations:
- **ID read.** Returns a four-item identification sequence.
- **Status read.** Holds the status value on the bus for as long as status mode lasts.
- **Page read.** Counts address cycles, waits busy for a fixed time while it fills a small register page buffer, then streams page data from the latched column.
- **Cache read.** Cache-start and cache-last act as read confirms. Cache-exit stops the stream.

A program setup command is accepted: it collects its address cycles and then returns to idle. Program data and erase are not stored. The page buffer is filled with a computed pattern, since the block has no backing store.

**States and transitions.**

| State | Meaning | Transitions |
|---|---|---|
| IDLE | Nothing is driven | Read-setup, ID or program-setup go to ADDR. Status goes to STATUS. Reset, cache-exit and other codes go to IDLE. |
| ADDR | Collecting address cycles | After the last cycle: ID goes to IDOUT, read-setup goes to WAITCONF, program-setup goes to IDLE. |
| WAITCONF | Address complete, waiting for a confirm | A read confirm goes to BUSY. |
| BUSY | Page load in progress | When the busy counter expires, goes to STREAM. |
| STREAM | Page data is served | — |
| IDOUT | ID items are served | — |
| STATUS | Status value is served | — |

Any accepted command byte leaves STREAM, IDOUT or STATUS by the same rules as from IDLE.

Top module: `nfc_responder`

## Requirements
- R1: After reset the ready output is 1 and the bus output is 0.
- R2: While chip enable (active low) is high, the bus output is 0, and write and read strobes change no state.
- R3: Command 0x90 followed by one address cycle gives, on successive reads: the manufacturer ID, the device ID, 0xA5, and then 0x15 on an 8-bit bus or 0x55 on a 16-bit bus. After that, reads give 0. On a 16-bit bus each item sits in bits 7:0 and bits 15:8 are 0.
- R4: After command 0x70, every read returns the status byte {unprotect flag, 1, 1, 00000} in bits 7:0, and does not advance. This holds until another command byte is latched.
- R5: After command 0x00, a read confirm is honoured only after 4 address cycles when CAP_MBIT ≤ 1024, or 5 when CAP_MBIT ≥ 2048. A confirm that comes earlier is ignored and ready stays 1.
- R6: With command 0x00 latched and the address complete, the confirm codes 0x30, 0x31 and 0x3F all start the same page load. Ready goes low for exactly BUSY_CYC clocks.
- R7: Page byte i holds (first row address byte + i) mod 256. A 16-bit read returns byte p in bits 7:0 and byte p+1 in bits 15:8, and the pointer then advances by 2. An 8-bit read advances by 1.
- R8: Streaming starts at byte column × (bus width in bytes). The column is taken from address cycles 1 (low) and 2 (high).
- R9: Once fewer than one full bus word of the page remains, reads return 0.
- R10: Command 0x34 ends streaming. Reads then return 0, and a following confirm without a new address sequence is ignored.
- R11: Command 0xFF returns the block to idle, so reads give 0. A later status read still reports the unprotect flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; a byte is latched on its rising edge |
| re_n | input | 1 | Read strobe; output advances on its rising edge |
| io_in | input | BUS_W | Command, address and data input |
| io_out | output | BUS_W | Data output; 0 when nothing is served |
| rdy | output | 1 | Ready (1) or busy (0) |

## Verification
The hardest case to reach is the address-count boundary. It needs a confirm that arrives one address cycle too early on a 5-cycle device, while a 4-cycle device sharing the same strobes takes that same confirm. Two instances share the strobe lines and have separate chip enables. The first is 8 bits wide and uses 4 cycles; the second is 16 bits wide and uses 5. After four address bytes and a confirm, only the first goes busy. Chip enable then steers a fifth address byte and a cache-start confirm to the second instance alone. This same sequence also exercises column scaling on the 16-bit bus and the end-of-page cut-off.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_WAITCONF, ST_BUSY, ST_STREAM, ST_IDOUT, ST_STATUS
    } nfc_state_e;

    localparam logic [7:0] OP_RD_SETUP   = 8'h00;
    localparam logic [7:0] OP_RD_CONF    = 8'h30;
    localparam logic [7:0] OP_CACHE_GO   = 8'h31;
    localparam logic [7:0] OP_CACHE_LAST = 8'h3F;
    localparam logic [7:0] OP_CACHE_EXIT = 8'h34;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] OP_PROG_SETUP = 8'h80;
    localparam logic [7:0] OP_IDENT      = 8'h90;
    localparam logic [7:0] OP_RESET      = 8'hFF;
endpackage

// File: rtl/nfc_strobe.sv
module nfc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic cle,
    input  logic ale,
    input  logic we_n,
    input  logic re_n,
    output logic cmd_wr,
    output logic addr_wr,
    output logic rd_done
);
    logic we_q, re_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    logic we_rise;
    assign we_rise = we_n & ~we_q & ~ce_n;
    assign cmd_wr  = we_rise & cle & ~ale;
    assign addr_wr = we_rise & ale & ~cle;
    assign rd_done = re_n & ~re_q & ~ce_n;
endmodule

// File: rtl/nfc_page_buf.sv
module nfc_page_buf #(
    parameter int BUS_W      = 8,
    parameter int PAGE_BYTES = 16,
    parameter int COL_W      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       seed,
    input  logic [COL_W-1:0] col_byte,
    input  logic             advance,
    output logic [BUS_W-1:0] word,
    output logic             avail
);
    localparam int BYTES = BUS_W / 8;
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int PTR_W = COL_W + 1;

    logic [7:0]       mem [PAGE_BYTES];
    logic [PTR_W-1:0] ptr;

    assign avail = (ptr + PTR_W'(BYTES)) <= PTR_W'(PAGE_BYTES);

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    mem[i] <= 8'h00;
            else if (load) mem[i] <= seed + 8'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ptr <= '0;
        else if (load)             ptr <= {1'b0, col_byte};
        else if (advance && avail) ptr <= ptr + PTR_W'(BYTES);
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < BYTES; k++)
            word[k*8 +: 8] = avail ? mem[ptr[IDX_W-1:0] + IDX_W'(k)] : 8'h00;
    end
endmodule

// File: rtl/nfc_responder.sv
module nfc_responder
    import nfc_pkg::*;
#(
    parameter int         BUS_W      = 8,
    parameter int         CAP_MBIT   = 1024,
    parameter int         PAGE_BYTES = 16,
    parameter int         BUSY_CYC   = 6,
    parameter logic [7:0] MANF_ID    = 8'h2C,
    parameter logic [7:0] DEV_ID     = 8'hDA,
    parameter logic       UNPROT     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic [BUS_W-1:0] io_in,
    output logic [BUS_W-1:0] io_out,
    output logic             rdy
);
    localparam int         BYTES    = BUS_W / 8;
    localparam int         ADDR_CYC = (CAP_MBIT >= 2048) ? 5 : 4;
    localparam int         CNT_W    = $clog2(BUSY_CYC + 1);
    localparam int         COL_W    = 17;
    localparam logic [7:0] ID_LAST  = (BUS_W == 16) ? 8'h55 : 8'h15;
    localparam logic [7:0] STAT_VAL = {UNPROT, 2'b11, 5'b00000};

    nfc_state_e       state, nxt;
    logic [7:0]       cmd;
    logic [2:0]       acnt;
    logic [COL_W-1:0] col;
    logic [7:0]       row_lo;
    logic [CNT_W-1:0] bcnt;
    logic [2:0]       id_idx;
    logic             cmd_wr, addr_wr, rd_done;
    logic [BUS_W-1:0] page_word;
    logic             page_avail, load;
    logic [7:0]       b;
    logic             unused_hi;

    assign b         = io_in[7:0];
    assign unused_hi = ^io_in;

    nfc_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n),
        .cmd_wr(cmd_wr), .addr_wr(addr_wr), .rd_done(rd_done)
    );

    assign load = (state == ST_BUSY) && (bcnt == '0);

    nfc_page_buf #(.BUS_W(BUS_W), .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_page (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(row_lo), .col_byte(col),
        .advance(rd_done && state == ST_STREAM), .word(page_word), .avail(page_avail)
    );

    logic is_conf, fold, cmd_take, addr_take, addr_last;
    assign is_conf   = (b == OP_RD_CONF) || (b == OP_CACHE_GO) || (b == OP_CACHE_LAST);
    assign fold      = (cmd == OP_RD_SETUP) && is_conf;
    assign cmd_take  = cmd_wr && (state != ST_BUSY);
    assign addr_take = addr_wr && (state == ST_ADDR);
    assign addr_last = (cmd == OP_IDENT) ? (acnt == 3'd0) : (acnt == 3'(ADDR_CYC - 1));

    // next-state logic
    always_comb begin
        nxt = state;
        if (cmd_take) begin
            if (fold) begin
                if (state == ST_WAITCONF) nxt = ST_BUSY;
            end else begin
                unique case (b)
                    OP_RD_SETUP, OP_IDENT, OP_PROG_SETUP: nxt = ST_ADDR;
                    OP_STATUS:                            nxt = ST_STATUS;
                    default:                              nxt = ST_IDLE;
                endcase
            end
        end else if (addr_take && addr_last) begin
            if (cmd == OP_IDENT)         nxt = ST_IDOUT;
            else if (cmd == OP_RD_SETUP) nxt = ST_WAITCONF;
            else                         nxt = ST_IDLE;
        end else if (load) begin
            nxt = ST_STREAM;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd    <= OP_RESET;
            acnt   <= '0;
            col    <= '0;
            row_lo <= '0;
            bcnt   <= '0;
            id_idx <= '0;
        end else begin
            if (cmd_take && !fold) begin
                cmd  <= (b == OP_CACHE_EXIT) ? OP_RD_SETUP : b;
                acnt <= '0;
            end
            if (addr_take) begin
                acnt <= acnt + 3'd1;
                case (acnt)
                    3'd0:    col    <= {9'b0, b};
                    3'd1:    col    <= {1'b0, b, col[7:0]} << (BYTES - 1);
                    3'd2:    row_lo <= b;
                    default: ;
                endcase
            end
            if (nxt == ST_BUSY && state != ST_BUSY) bcnt <= CNT_W'(BUSY_CYC - 1);
            else if (state == ST_BUSY && bcnt != '0) bcnt <= bcnt - 1'b1;
            if (nxt == ST_IDOUT && state != ST_IDOUT)               id_idx <= '0;
            else if (state == ST_IDOUT && rd_done && id_idx < 3'd4) id_idx <= id_idx + 3'd1;
        end
    end

    // outputs
    logic [7:0] id_item;
    always_comb begin
        case (id_idx)
            3'd0:    id_item = MANF_ID;
            3'd1:    id_item = DEV_ID;
            3'd2:    id_item = 8'hA5;
            3'd3:    id_item = ID_LAST;
            default: id_item = 8'h00;
        endcase
    end

    always_comb begin
        io_out = '0;
        rdy    = (state != ST_BUSY);
        if (!ce_n) begin
            unique case (state)
                ST_IDOUT:  io_out = BUS_W'(id_item);
                ST_STATUS: io_out = BUS_W'(STAT_VAL);
                ST_STREAM: io_out = page_avail ? page_word : '0;
                ST_IDLE, ST_ADDR, ST_WAITCONF, ST_BUSY: io_out = '0;
            endcase
        end
    end
endmodule

// File: rtl/nfc_responder_chk.sv
module nfc_responder_chk
    import nfc_pkg::*;
#(
    parameter int   BUS_W    = 8,
    parameter int   CAP_MBIT = 1024,
    parameter int   BUSY_CYC = 6,
    parameter logic UNPROT   = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic [BUS_W-1:0] io_in,
    input logic [BUS_W-1:0] io_out,
    input logic             rdy,
    input nfc_state_e       state,
    input logic [2:0]       acnt
);
    localparam int         ADDR_CYC = (CAP_MBIT >= 2048) ? 5 : 4;
    localparam logic [7:0] STAT_VAL = {UNPROT, 2'b11, 5'b00000};

    int unsigned low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   low_run <= 0;
        else if (rdy) low_run <= 0;
        else          low_run <= low_run + 1;
    end

    AST_CE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> io_out == '0); // R2
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> low_run < BUSY_CYC); // R6
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> ($past(io_in[7:0]) == 8'h30 || $past(io_in[7:0]) == 8'h31
                        || $past(io_in[7:0]) == 8'h3F)); // R6
    AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        acnt <= 3'(ADDR_CYC)); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STATUS && $past(state) == ST_STATUS && !ce_n)
            |-> io_out[7:0] == STAT_VAL); // R4

    if (BUS_W > 8) begin : g_wide
        AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!ce_n && (state == ST_IDOUT || state == ST_STATUS))
                |-> io_out[BUS_W-1:8] == '0); // R3
    end
endmodule

bind nfc_responder nfc_responder_chk #(
    .BUS_W(BUS_W), .CAP_MBIT(CAP_MBIT), .BUSY_CYC(BUSY_CYC), .UNPROT(UNPROT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .io_in(io_in), .io_out(io_out),
    .rdy(rdy), .state(state), .acnt(acnt)
);

// File: tb/sim_nfc_responder.sv
`timescale 1ns/1ps
module sim_nfc_responder;
    localparam int BUSY = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce0_n = 1'b1, ce1_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [15:0] io = '0;
    logic [7:0]  o0;
    logic [15:0] o1;
    logic        rdy0, rdy1;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nfc_responder #(.BUS_W(8), .CAP_MBIT(1024), .BUSY_CYC(BUSY), .DEV_ID(8'hDA)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce0_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_in(io[7:0]), .io_out(o0), .rdy(rdy0));

    nfc_responder #(.BUS_W(16), .CAP_MBIT(2048), .BUSY_CYC(BUSY), .DEV_ID(8'hCA)) u1 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce1_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_in(io), .io_out(o1), .rdy(rdy1));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic c, input logic a, input logic [7:0] v);
        @(negedge clk);
        cle = c; ale = a; io = {8'h00, v}; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v0, output logic [15:0] v1);
        @(negedge clk);
        re_n = 1'b0;
        @(negedge clk);
        v0 = o0; v1 = o1;
        re_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic busy_len(input bit which, output int n);
        n = 0;
        while ((which ? !rdy1 : !rdy0) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        ce0_n = 1'b0; ce1_n = 1'b0;
        @(negedge clk);
        chk("R1 rdy0", 16'(rdy0), 16'h1);
        chk("R1 rdy1", 16'(rdy1), 16'h1);
        chk("R1 o0", 16'(o0), 16'h0);
        chk("R1 o1", o1, 16'h0);
    endtask

    task automatic t_read_id();
        logic [7:0] a; logic [15:0] w;
        logic [7:0] e0 [5] = '{8'h2C, 8'hDA, 8'hA5, 8'h15, 8'h00};
        logic [15:0] e1 [5] = '{16'h002C, 16'h00CA, 16'h00A5, 16'h0055, 16'h0000};
        ce0_n = 1'b0; ce1_n = 1'b0;
        wr_byte(1, 0, 8'h90);
        wr_byte(0, 1, 8'h00);
        for (int i = 0; i < 5; i++) begin
            rd(a, w);
            chk("R3 id x8", 16'(a), 16'(e0[i]));
            chk("R3 id x16", w, e1[i]);
        end
    endtask

    task automatic t_status();
        logic [7:0] a; logic [15:0] w;
        ce0_n = 1'b0; ce1_n = 1'b0;
        wr_byte(1, 0, 8'h70);
        for (int i = 0; i < 3; i++) begin
            rd(a, w);
            chk("R4 sticky x8", 16'(a), 16'h00E0);
            chk("R4 sticky x16", w, 16'h00E0);
        end
        // R2: u1 deselected while u0 takes an ID command
        ce1_n = 1'b1;
        wr_byte(1, 0, 8'h90);
        wr_byte(0, 1, 8'h00);
        ce0_n = 1'b1; ce1_n = 1'b0;
        rd(a, w);
        chk("R2 deselected strobes ignored", w, 16'h00E0);
        chk("R2 o0 quiet", 16'(a), 16'h0);
        ce0_n = 1'b0; ce1_n = 1'b1;
        rd(a, w);
        chk("R3 id after new command", 16'(a), 16'h002C);
        chk("R2 o1 quiet", w, 16'h0);
        ce1_n = 1'b0;
        wr_byte(1, 0, 8'hFF);
        rd(a, w);
        chk("R11 reset x8", 16'(a), 16'h0);
        chk("R11 reset x16", w, 16'h0);
        wr_byte(1, 0, 8'h70);
        rd(a, w);
        chk("R11 flag kept x8", 16'(a), 16'h00E0);
        chk("R11 flag kept x16", w, 16'h00E0);
        wr_byte(1, 0, 8'h00);
        rd(a, w);
        chk("R4 ends on new command", 16'(a), 16'h0);
    endtask

    task automatic t_addr_count();
        logic [7:0] a; logic [15:0] w; int n;
        ce0_n = 1'b0; ce1_n = 1'b0;
        wr_byte(1, 0, 8'h00);
        wr_byte(0, 1, 8'h02);
        wr_byte(0, 1, 8'h00);
        wr_byte(0, 1, 8'h40);
        wr_byte(0, 1, 8'h00);
        wr_byte(1, 0, 8'h30);
        chk("R5 x16 early confirm ignored", 16'(rdy1), 16'h1);
        busy_len(1'b0, n);
        chk("R6 busy length x8", 16'(n), 16'(BUSY));
        ce1_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            rd(a, w);
            chk("R7 R8 stream x8", 16'(a), 16'(8'h42 + 8'(i)));
        end
        rd(a, w);
        chk("R9 end of page x8", 16'(a), 16'h0);
        ce0_n = 1'b1; ce1_n = 1'b0;
        wr_byte(0, 1, 8'h00);
        wr_byte(1, 0, 8'h31);
        busy_len(1'b1, n);
        chk("R6 busy length x16 cache start", 16'(n), 16'(BUSY));
        for (int i = 0; i < 6; i++) begin
            rd(a, w);
            chk("R7 R8 stream x16", w, {8'h45 + 8'(2*i), 8'h44 + 8'(2*i)});
        end
        rd(a, w);
        chk("R9 end of page x16", w, 16'h0);
    endtask

    task automatic t_cache_exit();
        logic [7:0] a; logic [15:0] w; int n;
        ce0_n = 1'b0; ce1_n = 1'b1;
        wr_byte(1, 0, 8'h00);
        wr_byte(0, 1, 8'h05);
        wr_byte(0, 1, 8'h00);
        wr_byte(0, 1, 8'h10);
        wr_byte(0, 1, 8'h00);
        wr_byte(1, 0, 8'h3F);
        busy_len(1'b0, n);
        chk("R6 busy length cache last", 16'(n), 16'(BUSY));
        rd(a, w);
        chk("R7 cache last data x8", 16'(a), 16'h0015);
        wr_byte(1, 0, 8'h34);
        rd(a, w);
        chk("R10 exit x8", 16'(a), 16'h0);
        wr_byte(1, 0, 8'h30);
        @(negedge clk);
        chk("R10 confirm after exit ignored", 16'(rdy0), 16'h1);
        ce0_n = 1'b1; ce1_n = 1'b0;
        wr_byte(1, 0, 8'h00);
        wr_byte(0, 1, 8'h01);
        wr_byte(0, 1, 8'h00);
        wr_byte(0, 1, 8'h20);
        wr_byte(0, 1, 8'h00);
        wr_byte(0, 1, 8'h00);
        wr_byte(1, 0, 8'h30);
        busy_len(1'b1, n);
        rd(a, w);
        chk("R8 x16 column one", w, 16'h2322);
        wr_byte(1, 0, 8'h34);
        rd(a, w);
        chk("R10 exit x16", w, 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_id();
        t_status();
        t_addr_count();
        t_cache_exit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule